// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames into host memory. The host keeps a ring of descriptors in memory. Each descriptor is four 32-bit words: a next-descriptor pointer at offset 0, a status word at offset 4, a buffer address at offset 8 and a length/control word at offset 12. The engine walks the ring through the next pointers. For each descriptor it reads the status word first. A zero status means the host has given the descriptor back. The engine then fetches the buffer address and the buffer size, stores the incoming bytes into the buffer, and writes a completion status.

A non-zero status means the host has not yet returned that descriptor. In that case the engine writes nothing and holds the incoming frame stalled. It reads the same status word again after a programmable poll period. The host frees a descriptor by zeroing its status word, and reception resumes at that entry.

The host programs four settings through a small register-write port: the start of the list, the poll period, the largest legal frame size and an enable. Frames arrive as a byte stream with a valid/ready handshake, an end-of-frame marker and an error flag. Memory is reached through a synchronous master port: read data returns on the cycle after the request, and writes carry byte enables.

Top module: `rxring_engine`

## Requirements
- R1: While reset is asserted, and until the enable (select 3, bit 0) is written to 1, `mem_req` and `in_ready` stay low.
- R2: Enabling the engine loads the list pointer (select 0). For the current descriptor address D, the engine reads D+4. If that word is zero, it reads D+8 (buffer address) and then D+12 (buffer size in bits 12:0; bit 31 is ignored). Only after these reads does it raise `in_ready`. No descriptor read overlaps the time `in_ready` is high.
- R3: Frame byte k goes to buffer address B+(k & ~3), on byte lane k mod 4 (lane 0 = bits 7:0). The byte enables cover only the lanes this frame wrote in that word.
- R4: When the byte flagged `in_last` is accepted, the engine writes the status word at D+4. The status has bit 15 set, and bits 12:0 hold the frame byte count, saturating at 8191.
- R5: If `in_err` was high on any byte of the frame, status bit 14 is set.
- R6: Bytes at index ≥ the buffer size are accepted but never written to memory, and status bit 16 is set.
- R7: A frame whose byte count is greater than the maximum frame size (select 2) gets status bit 17.
- R8: After the status write, the engine reads D+0 and uses that word as the next descriptor address, so the last descriptor pointing to the first closes the ring.
- R9: While the status word read at D+4 is non-zero, the engine makes no memory write and keeps `in_ready` low. It re-reads D+4 every max(P,1)·POLL_UNIT+2 cycles, where P is the 8-bit poll period (select 1).
- R10: Once the host writes zero to a held descriptor's status, the engine's next poll accepts that descriptor, and the stalled frame is stored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 list pointer, 1 poll period, 2 max frame size, 3 enable |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Frame error indication |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (0 = read) |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
Every descriptor read is a request cycle followed by a wait cycle, so read data is used exactly one cycle after its request. Data writes issue in the same cycle as the byte that completes a lane group. The status write follows one cycle after the last byte is taken. The scoreboard monitor samples the memory port on falling edges and compares each status write against the next queued expectation as it appears, so no fixed delay is assumed there. The poll spacing is checked exactly, by counting cycles between consecutive reads of the held status word against max(P,1)·POLL_UNIT+2.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   localparam int LEN_W  = 13;
   localparam int OWN_B  = 15;
   localparam int BAD_B  = 14;
   localparam int OVF_B  = 16;
   localparam int LONG_B = 17;

   typedef enum logic [3:0] {
      S_OFF, S_RD_STAT, S_WT_STAT, S_POLL, S_RD_BUF, S_WT_BUF,
      S_RD_LEN, S_WT_LEN, S_RECV, S_WR_STAT, S_RD_NEXT, S_WT_NEXT
   } rx_st_e;

   function automatic logic [31:0] mk_status(input logic [LEN_W-1:0] len,
                                             input logic bad, input logic ovf,
                                             input logic lng);
      logic [31:0] s;
      s = '0;
      s[LEN_W-1:0] = len;
      s[OWN_B]     = 1'b1;
      s[BAD_B]     = bad;
      s[OVF_B]     = ovf;
      s[LONG_B]    = lng;
      return s;
   endfunction
endpackage

// File: rtl/rxring_cfg.sv
module rxring_cfg #(
   parameter int AW       = 32,
   parameter int POLL_W   = 8,
   parameter int MFS_W    = 13,
   parameter int POLL_RST = 100,
   parameter int MFS_RST  = 1528
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [AW-1:0]     lptr,
   output logic [POLL_W-1:0] poll_per,
   output logic [MFS_W-1:0]  max_fs,
   output logic              en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lptr     <= '0;
         poll_per <= POLL_W'(POLL_RST);
         max_fs   <= MFS_W'(MFS_RST);
         en       <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            2'd0:    lptr     <= cfg_wdata[AW-1:0];
            2'd1:    poll_per <= cfg_wdata[POLL_W-1:0];
            2'd2:    max_fs   <= cfg_wdata[MFS_W-1:0];
            default: en       <= cfg_wdata[0];
         endcase
      end
   end
endmodule

// File: rtl/rxring_poll_timer.sv
module rxring_poll_timer #(
   parameter int POLL_W    = 8,
   parameter int POLL_UNIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [POLL_W-1:0] period,
   output logic              done
);
   localparam int TW = POLL_W + $clog2(POLL_UNIT + 1);

   logic [TW-1:0] cnt, scaled, load;

   generate
      if (POLL_UNIT == 1) begin : g_unit1
         assign scaled = TW'(period);
      end else begin : g_unitn
         assign scaled = TW'(period) * TW'(POLL_UNIT);
      end
   endgenerate

   assign load = (period == '0) ? TW'(POLL_UNIT) : scaled;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (start)          cnt <= load;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign done = (cnt == TW'(1));
endmodule

// File: rtl/rxring_lane_pack.sv
module rxring_lane_pack #(
   parameter bit LITTLE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        push,
   input  logic [1:0]  lane,
   input  logic [7:0]  byt,
   output logic [31:0] word_nx,
   output logic [3:0]  be_nx
);
   logic [31:0] acc;
   logic [1:0]  slot;
   logic [3:0]  upto;

   always_comb begin
      case (lane)
         2'd0:    upto = 4'b0001;
         2'd1:    upto = 4'b0011;
         2'd2:    upto = 4'b0111;
         default: upto = 4'b1111;
      endcase
   end

   generate
      if (LITTLE) begin : g_le
         assign slot  = lane;
         assign be_nx = upto;
      end else begin : g_be
         assign slot  = ~lane;
         assign be_nx = {upto[0], upto[1], upto[2], upto[3]};
      end
   endgenerate

   always_comb begin
      word_nx = acc;
      word_nx[8*slot +: 8] = byt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc <= '0;
      else if (push)     acc <= word_nx;
   end
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
   import rxring_pkg::*;
#(
   parameter int AW           = 32,
   parameter int POLL_W       = 8,
   parameter int POLL_UNIT    = 4,
   parameter int MFS_W        = 13,
   parameter int CNT_W        = 16,
   parameter bit LITTLE_LANES = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_last,
   input  logic          in_err,
   output logic          in_ready,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'((1 << LEN_W) - 1);

   generate
      if (AW < 8 || AW > 32)     begin : g_bad_aw  $error("AW out of range");        end
      if (POLL_UNIT < 1)         begin : g_bad_pu  $error("POLL_UNIT must be >= 1"); end
      if (CNT_W <= LEN_W)        begin : g_bad_cw  $error("CNT_W too narrow");       end
      if (CNT_W > AW)            begin : g_bad_cw2 $error("CNT_W exceeds AW");       end
      if (MFS_W > CNT_W)         begin : g_bad_mfs $error("MFS_W exceeds CNT_W");    end
   endgenerate

   logic [AW-1:0]     lptr;
   logic [POLL_W-1:0] poll_per;
   logic [MFS_W-1:0]  max_fs;
   logic              en;

   rxring_cfg #(.AW(AW), .POLL_W(POLL_W), .MFS_W(MFS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .lptr(lptr), .poll_per(poll_per),
      .max_fs(max_fs), .en(en));

   rx_st_e st, st_nx;
   logic [AW-1:0]    cur, buf_base;
   logic [LEN_W-1:0] buf_size;
   logic [CNT_W-1:0] cnt;
   logic             bad_q, ovf_q;
   logic             t_start, t_done;

   assign t_start = (st == S_WT_STAT) && (mem_rdata != '0);

   rxring_poll_timer #(.POLL_W(POLL_W), .POLL_UNIT(POLL_UNIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(t_start), .period(poll_per),
      .done(t_done));

   logic        fire, in_buf, lane_end, data_wr;
   logic [1:0]  lane;
   logic [31:0] word_nx, stat_word;
   logic [3:0]  be_nx;
   logic [LEN_W-1:0] len_sat;
   logic        too_long;
   logic        is_wr_stat, is_wt_stat, is_wt_next;

   assign in_ready = (st == S_RECV);
   assign fire     = in_ready && in_valid;
   assign lane     = cnt[1:0];
   assign in_buf   = cnt < CNT_W'(buf_size);
   assign lane_end = (lane == 2'd3) || in_last || ((cnt + 1'b1) == CNT_W'(buf_size));
   assign data_wr  = fire && in_buf && lane_end;

   rxring_lane_pack #(.LITTLE(LITTLE_LANES)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(st == S_WT_LEN), .push(fire && in_buf),
      .lane(lane), .byt(in_data), .word_nx(word_nx), .be_nx(be_nx));

   assign len_sat   = (cnt > LEN_MAX) ? LEN_MAX[LEN_W-1:0] : cnt[LEN_W-1:0];
   assign too_long  = cnt > CNT_W'(max_fs);
   assign stat_word = mk_status(len_sat, bad_q, ovf_q, too_long);

   assign is_wr_stat = (st == S_WR_STAT);
   assign is_wt_stat = (st == S_WT_STAT);
   assign is_wt_next = (st == S_WT_NEXT);

   always_comb begin
      st_nx = st;
      case (st)
         S_OFF:     if (en) st_nx = S_RD_STAT;
         S_RD_STAT: st_nx = en ? S_WT_STAT : S_OFF;
         S_WT_STAT: st_nx = (mem_rdata == '0) ? S_RD_BUF : S_POLL;
         S_POLL:    if (!en) st_nx = S_OFF; else if (t_done) st_nx = S_RD_STAT;
         S_RD_BUF:  st_nx = S_WT_BUF;
         S_WT_BUF:  st_nx = S_RD_LEN;
         S_RD_LEN:  st_nx = S_WT_LEN;
         S_WT_LEN:  st_nx = S_RECV;
         S_RECV:    if (fire && in_last) st_nx = S_WR_STAT;
         S_WR_STAT: st_nx = S_RD_NEXT;
         S_RD_NEXT: st_nx = S_WT_NEXT;
         S_WT_NEXT: st_nx = S_RD_STAT;
         default:   st_nx = S_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_OFF;
         cur      <= '0;
         buf_base <= '0;
         buf_size <= '0;
         cnt      <= '0;
         bad_q    <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         st <= st_nx;
         case (st)
            S_OFF:     if (en) cur <= lptr;
            S_WT_BUF:  buf_base <= mem_rdata[AW-1:0];
            S_WT_LEN: begin
               buf_size <= mem_rdata[LEN_W-1:0];
               cnt      <= '0;
               bad_q    <= 1'b0;
               ovf_q    <= 1'b0;
            end
            S_RECV: if (fire) begin
               if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
               if (in_err)  bad_q <= 1'b1;
               if (!in_buf) ovf_q <= 1'b1;
            end
            S_WT_NEXT: cur <= mem_rdata[AW-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = 4'h0;
      mem_wdata = '0;
      case (st)
         S_RD_STAT: begin mem_req = 1'b1; mem_addr = cur + AW'(4);  end
         S_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur + AW'(8);  end
         S_RD_LEN:  begin mem_req = 1'b1; mem_addr = cur + AW'(12); end
         S_RD_NEXT: begin mem_req = 1'b1; mem_addr = cur;           end
         S_RECV: begin
            mem_req   = data_wr;
            mem_we    = data_wr;
            mem_addr  = buf_base + AW'({cnt[CNT_W-1:2], 2'b00});
            mem_be    = be_nx;
            mem_wdata = word_nx;
         end
         S_WR_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur + AW'(4);
            mem_be    = 4'hF;
            mem_wdata = stat_word;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic [31:0]   mem_rdata,
   input logic          in_ready,
   input logic          is_wr_stat,
   input logic          is_wt_stat,
   input logic          is_wt_next,
   input logic [AW-1:0] cur,
   input logic [AW-1:0] buf_base,
   input logic [12:0]   buf_size
);
   p_own_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr_stat |-> (mem_req && mem_we && mem_wdata[15] && mem_addr == cur + AW'(4)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wt_stat && mem_rdata != '0) |=> (!mem_we && !in_ready));

   p_in_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !is_wr_stat) |->
         ((mem_addr - buf_base) < {{(AW-13){1'b0}}, buf_size}));

   p_next_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_wt_next |=> (cur == $past(mem_rdata[AW-1:0])));

   p_no_fetch_in_recv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !(mem_req && !mem_we));
endmodule

bind rxring_engine rxring_engine_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
   .in_ready(in_ready), .is_wr_stat(is_wr_stat), .is_wt_stat(is_wt_stat),
   .is_wt_next(is_wt_next), .cur(cur), .buf_base(buf_base),
   .buf_size(buf_size));

// File: tb/rxring_engine_bench.sv
module rxring_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic [3:0]  mem_be;

   always #4 clk = ~clk;

   rxring_engine u_rxring_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   logic [31:0] mem [0:255];
   logic        fill = 1'b0, host_we = 1'b0;
   logic [7:0]  host_idx = '0;
   logic [31:0] host_dat = '0;

   always @(posedge clk) begin
      if (fill) begin
         for (int i = 0; i < 256; i++) mem[i] <= 32'hA5A5A5A5;
      end else if (host_we) mem[host_idx] <= host_dat;
      if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else mem_rdata <= mem[mem_addr[9:2]];
      end
   end

   int total = 0, bad = 0, cyc = 0, wr_cnt = 0, rd4_prev = 0, rd4_last = 0;
   bit finished = 1'b0;
   logic [31:0] qa[$], qd[$], rd_log[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: status writes are compared as they occur
   always @(negedge clk) begin
      cyc++;
      if (rst_n && mem_req) begin
         if (mem_we) begin
            wr_cnt++;
            if (mem_addr < 64 && mem_addr[3:0] == 4'h4 && mem_be == 4'hF) begin
               if (qa.size() == 0) chk(1'b0, "R4 unexpected status", mem_wdata, 32'h0);
               else begin
                  logic [31:0] ea, ed;
                  ea = qa.pop_front();
                  ed = qd.pop_front();
                  chk(mem_addr == ea && mem_wdata == ed, "R4/R5/R6/R7 status",
                      mem_wdata, ed);
               end
            end
         end else begin
            rd_log.push_back(mem_addr);
            if (mem_addr == 32'h4) begin
               rd4_prev = rd4_last;
               rd4_last = cyc;
            end
         end
      end
   end

   function automatic logic [31:0] exp_stat(int n, bit err, int bsz, int mfs);
      logic [31:0] s;
      s = 32'((n > 8191) ? 8191 : n);
      s[15] = 1'b1;
      if (err)     s[14] = 1'b1;
      if (n > bsz) s[16] = 1'b1;
      if (n > mfs) s[17] = 1'b1;
      return s;
   endfunction

   task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic host_wr(input int idx, input logic [31:0] d);
      @(negedge clk); host_we = 1'b1; host_idx = 8'(idx); host_dat = d;
      @(negedge clk); host_we = 1'b0;
   endtask

   // Driver: pushes the expected status, then streams the bytes
   task automatic send_frame(input int n, input int base, input bit err,
                             input int desc, input int bsz, input int mfs);
      qa.push_back(32'(desc * 16 + 4));
      qd.push_back(exp_stat(n, err, bsz, mfs));
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = 8'(base + k);
         in_last = (k == n - 1); in_err = err && (k == n - 1);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t;
      t = 0;
      while (qa.size() != 0 && t < 2000) begin @(negedge clk); t++; end
      chk(qa.size() == 0, req, 32'(qa.size()), 32'h0);
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [7:0] mbyte(input int a);
      return mem[a >> 2][8*(a % 4) +: 8];
   endfunction

   task automatic check_buf(input int ba, input int start, input int n,
                            input int bsz, input string req);
      int kept, lim, badk;
      logic [7:0] e, a;
      kept = (n < bsz) ? n : bsz;
      lim  = kept + 4;
      badk = -1;
      for (int k = 0; k < lim; k++) begin
         e = (k < kept) ? 8'(start + k) : 8'hA5;
         if (mbyte(ba + k) != e && badk < 0) badk = k;
      end
      if (badk < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, req, 32'(mbyte(ba + badk)),
               32'((badk < kept) ? 8'(start + badk) : 8'hA5));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=0", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int bsz[4];
      int w0;
      bsz = '{32, 32, 6, 64};
      @(negedge clk); fill = 1'b1;
      @(negedge clk); fill = 1'b0;
      for (int d = 0; d < 4; d++) begin
         host_wr(d*4 + 0, 32'(((d + 1) % 4) * 16));
         host_wr(d*4 + 1, 32'h0);
         host_wr(d*4 + 2, 32'(32'h100 + d * 32'h40));
         host_wr(d*4 + 3, 32'h80000000 | 32'(bsz[d]));
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset while disabled
      begin
         bit quiet;
         quiet = 1'b1;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (mem_req || in_ready) quiet = 1'b0;
         end
         chk(quiet, "R1 idle while disabled", {30'h0, mem_req, in_ready}, 32'h0);
      end
      cfg_wr(2'd0, 32'h0);
      cfg_wr(2'd1, 32'd2);
      cfg_wr(2'd2, 32'd40);
      chk(mem_req == 1'b0, "R1 no access before enable", {31'h0, mem_req}, 32'h0);
      cfg_wr(2'd3, 32'h1);

      // Frame A: desc0, clean
      send_frame(10, 8'h10, 1'b0, 0, 32, 40);
      wait_done("R4 frame A done");
      chk(rd_log.size() >= 5 && rd_log[0] == 4 && rd_log[1] == 8 && rd_log[2] == 12,
          "R2 fetch order", rd_log[1], 32'h8);
      chk(rd_log.size() >= 5 && rd_log[3] == 0 && rd_log[4] == 32'h14,
          "R8 next pointer followed", rd_log[4], 32'h14);
      check_buf(32'h100, 8'h10, 10, 32, "R3 frame A data");
      chk(mem[32'h108 >> 2] == 32'hA5A51918, "R3 partial byte enables",
          mem[32'h108 >> 2], 32'hA5A51918);

      // Frame B: desc1, error flag
      send_frame(5, 8'h20, 1'b1, 1, 32, 40);
      wait_done("R5 frame B done");
      check_buf(32'h140, 8'h20, 5, 32, "R5 frame B data");

      // Frame C: desc2, buffer of 6 bytes overflowed
      send_frame(9, 8'h30, 1'b0, 2, 6, 40);
      wait_done("R6 frame C done");
      check_buf(32'h180, 8'h30, 9, 6, "R6 bytes past buffer discarded");

      // Frame D: desc3, longer than max frame size
      send_frame(45, 8'h40, 1'b0, 3, 64, 40);
      wait_done("R7 frame D done");
      check_buf(32'h1C0, 8'h40, 45, 64, "R7 frame D data");

      // Ring wraps to desc0, still owned by host
      fork
         send_frame(3, 8'h70, 1'b0, 0, 32, 40);
         begin
            w0 = wr_cnt;
            repeat (40) @(negedge clk);
            chk(wr_cnt == w0, "R9 no writes while held", 32'(wr_cnt), 32'(w0));
            chk(in_ready == 1'b0, "R9 frame held", {31'h0, in_ready}, 32'h0);
            chk(rd4_last - rd4_prev == 10, "R9 poll spacing",
                32'(rd4_last - rd4_prev), 32'd10);
            host_wr(1, 32'h0);
         end
      join
      wait_done("R10 frame E done after release");
      chk(mem[32'h100 >> 2] == 32'h13727170, "R10 frame E stored in desc0",
          mem[32'h100 >> 2], 32'h13727170);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule